// File: doc/BRIEF.md
# Queued Event Process with Local Timers

This block is an extended finite-state process whose only input path is a message queue. External messages and the expiry signals of its own timers enter the same bounded FIFO. On every cycle where the step input is high and the queue holds an entry, the process consumes the entry at the head. If that message enables a transition from the current state, the transition is taken. If it does not, the message is thrown away.

Timers are owned by the process. A timer is started either by a transition or by the timer command port. When a timer runs out, it does not act on the state directly. It queues a timer message, and that message is handled only once it reaches the head of the queue. Stopping or restarting a timer also removes any of its timer messages still waiting in the queue, so a cancelled timeout can never fire late.

States (`state_o`): IDLE = 0, ARMED = 1, RUN = 2. Message code `code_o` = {timer flag, 3-bit code}. External codes: START = 1, ACK = 2, STOP = 3. A timer message carries flag 1 and the timer index as its code: the arm timer is index 0 and the idle timer is index 1. The transitions are:
- ARM: IDLE on START goes to ARMED and starts timer 0 for `ARM_DUR` cycles.
- CONFIRM: ARMED on ACK goes to RUN and stops timer 0.
- ABORT: ARMED on STOP goes to IDLE and stops timer 0.
- EXPIRE: ARMED on timer 0 goes to IDLE.
- HALT: RUN on STOP goes to IDLE.
- IDLEOUT: RUN on timer 1 goes to IDLE.

Top module: `evq_proc`

## Requirements
- R1: Reset behaviour. After reset the state is IDLE (0), `take_o` and `drop_o` are low, and `wr_rdy_o` is high because the queue is empty.
- R2: Consumption order. Messages are consumed one per step, oldest first. A message accepted at clock edge k is consumed at edge k+1 when `step_i` is high.
- R3: Transition table. Exactly the six transitions listed above (ARM, CONFIRM, ABORT, EXPIRE, HALT, IDLEOUT) are taken, using the codes and state encodings given above.
- R4: Discards. A consumed message that enables no transition from the current state pulses `drop_o` with its code, and the state does not change.
- R5: Step hold. While `step_i` is low, nothing is consumed and neither strobe pulses.
- R6: Timer expiry. A timer started at edge k with duration D enqueues its timer message at edge k+D. A duration of 0 counts as 1. The message is handled only when it reaches the head of the queue.
- R7: Arrival order. When an external write and a timer expiry arrive at the same edge, the external message is placed in the queue ahead of the timer message.
- R8: Full queue. With `DEPTH` entries queued, `wr_rdy_o` is low and writes are not accepted. A timer expiry that finds no room is held pending and is enqueued as soon as space frees.
- R9: Timer stop. Stopping a timer, by command or by the CONFIRM or ABORT transitions, halts it, cancels any pending expiry, and deletes its messages from the queue.
- R10: Timer restart. Setting a timer that is already running or already expired restarts it with the new duration and deletes its earlier queued message.
- R11: Strobes. `take_o` or `drop_o` is high for exactly one cycle per consumed message, the two are never high together, and `code_o` shows that message during the pulse.
- R12: Command priority. A timer command on the port overrides a transition action on the same timer in the same cycle. A stop command overrides a set command given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Allows one message to be consumed this cycle |
| wr_vld_i | input | 1 | External message valid |
| wr_code_i | input | 3 | External message code |
| wr_rdy_o | output | 1 | Queue can accept a message |
| tset_i | input | 1 | Start or restart the timer selected by `tidx_i` |
| tclr_i | input | 1 | Stop the timer selected by `tidx_i` |
| tidx_i | input | TIW | Timer index for the command |
| tdur_i | input | DUR_W | Duration for `tset_i`, in cycles |
| state_o | output | 2 | Current state |
| take_o | output | 1 | A transition was taken |
| drop_o | output | 1 | A message was discarded |
| code_o | output | 4 | Consumed message as {timer flag, code} |

## Verification
The bench aims at the places where a timer message and the queue interact.

- Expiry latency. If the timer acted directly instead of through the queue, the timeout transition would appear a cycle early, or even while `step_i` is low.
- Stale signals. If stop or restart failed to purge the queue, an old timer message would be consumed first and show up as an extra strobe with code 9.
- Same-edge arrivals. If the enqueue order were reversed, the code sequence would come out swapped.
- Full queue. If an expiry were lost while the queue was full, the last drain would be missing its code 9. If a write were accepted while full, an extra STOP would appear.
- Port versus transition. If the transition's arm action beat the port's stop command, the process would leave ARMED on its own.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } state_e;

    localparam logic [CODE_W-1:0] MSG_START = 3'd1;
    localparam logic [CODE_W-1:0] MSG_ACK   = 3'd2;
    localparam logic [CODE_W-1:0] MSG_STOP  = 3'd3;

    // timer indices used by the transition table
    localparam logic [CODE_W-1:0] TMR_ARM  = 3'd0;
    localparam logic [CODE_W-1:0] TMR_IDLE = 3'd1;

    typedef struct packed {
        logic              tmr;
        logic [CODE_W-1:0] code;
    } entry_t;

    // true when the entry is a timer message whose timer is flagged in mask
    function automatic logic tmr_hit(entry_t e, logic [7:0] mask);
        return e.tmr && mask[e.code];
    endfunction

endpackage

// File: rtl/evq_timer_bank.sv
module evq_timer_bank #(
    parameter int N_TMR = 2,
    parameter int DUR_W = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_TMR-1:0]            set_i,
    input  logic [N_TMR-1:0]            clr_i,
    input  logic [N_TMR-1:0][DUR_W-1:0] dur_i,
    input  logic [N_TMR-1:0]            acc_i,
    output logic [N_TMR-1:0]            fire_o
);

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic [DUR_W-1:0] cnt_q;
        logic             run_q;
        logic             pend_q;
        logic             expire;

        assign expire    = run_q && (cnt_q == DUR_W'(1));
        // a command this cycle suppresses any expiry of the same timer
        assign fire_o[t] = !set_i[t] && !clr_i[t] && (pend_q || expire);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cnt_q  <= '0;
                run_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (clr_i[t]) begin
                run_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (set_i[t]) begin
                run_q  <= 1'b1;
                pend_q <= 1'b0;
                cnt_q  <= (dur_i[t] == '0) ? DUR_W'(1) : dur_i[t];
            end else begin
                if (run_q) begin
                    if (expire) run_q <= 1'b0;
                    else        cnt_q <= cnt_q - DUR_W'(1);
                end
                pend_q <= fire_o[t] && !acc_i[t];
            end
        end
    end

endmodule

// File: rtl/evq_queue.sv
module evq_queue
    import evq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int N_TMR = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pop_i,
    input  logic [N_TMR-1:0]  kill_i,
    input  logic              wr_vld_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic [N_TMR-1:0]  tmr_req_i,
    output entry_t            head_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              wr_rdy_o,
    output logic [N_TMR-1:0]  tmr_acc_o
);

    entry_t           q_q [DEPTH];
    entry_t           q_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_c;
    logic [7:0]       kill_m;

    assign kill_m   = 8'(kill_i);
    assign head_o   = q_q[0];
    assign cnt_o    = cnt_q;
    assign wr_rdy_o = cnt_q < CNT_W'(DEPTH);

    // rebuild the queue in order: survivors, then the external write, then expiries
    always_comb begin
        q_d       = q_q;
        n_c       = '0;
        tmr_acc_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt_q && !(i == 0 && pop_i) && !tmr_hit(q_q[i], kill_m)) begin
                q_d[n_c[IDX_W-1:0]] = q_q[i];
                n_c = n_c + CNT_W'(1);
            end
        end
        if (wr_vld_i && wr_rdy_o) begin
            q_d[n_c[IDX_W-1:0]] = '{tmr: 1'b0, code: wr_code_i};
            n_c = n_c + CNT_W'(1);
        end
        for (int t = 0; t < N_TMR; t++) begin
            if (tmr_req_i[t] && n_c < CNT_W'(DEPTH)) begin
                q_d[n_c[IDX_W-1:0]] = '{tmr: 1'b1, code: CODE_W'(t)};
                n_c = n_c + CNT_W'(1);
                tmr_acc_o[t] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
        end else begin
            cnt_q <= n_c;
            q_q   <= q_d;
        end
    end

endmodule

// File: rtl/evq_fsm.sv
module evq_fsm
    import evq_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            head_ok_i,
    input  entry_t          head_i,
    output state_e          state_o,
    output logic            take_o,
    output logic            drop_o,
    output logic [CODE_W:0] code_o,
    output logic            arm_o,
    output logic            disarm_o
);

    state_e st_q, st_d;
    logic   hit;
    logic   ext_msg, tmr_msg;

    assign ext_msg = !head_i.tmr;
    assign tmr_msg =  head_i.tmr;

    // transition table
    always_comb begin
        st_d     = st_q;
        hit      = 1'b0;
        arm_o    = 1'b0;
        disarm_o = 1'b0;
        if (head_ok_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (ext_msg && head_i.code == MSG_START) begin   // ARM
                        st_d = ST_ARMED; hit = 1'b1; arm_o = 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (ext_msg && head_i.code == MSG_ACK) begin     // CONFIRM
                        st_d = ST_RUN; hit = 1'b1; disarm_o = 1'b1;
                    end else if (ext_msg && head_i.code == MSG_STOP) begin // ABORT
                        st_d = ST_IDLE; hit = 1'b1; disarm_o = 1'b1;
                    end else if (tmr_msg && head_i.code == TMR_ARM) begin  // EXPIRE
                        st_d = ST_IDLE; hit = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (ext_msg && head_i.code == MSG_STOP) begin    // HALT
                        st_d = ST_IDLE; hit = 1'b1;
                    end else if (tmr_msg && head_i.code == TMR_IDLE) begin // IDLEOUT
                        st_d = ST_IDLE; hit = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            take_o <= 1'b0;
            drop_o <= 1'b0;
            code_o <= '0;
        end else begin
            take_o <= head_ok_i && hit;
            drop_o <= head_ok_i && !hit;
            if (head_ok_i) code_o <= head_i;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/evq_proc.sv
module evq_proc
    import evq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int N_TMR   = 2,
    parameter int DUR_W   = 8,
    parameter int ARM_DUR = 6,
    localparam int TIW    = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              wr_vld_i,
    input  logic [CODE_W-1:0] wr_code_i,
    output logic              wr_rdy_o,
    input  logic              tset_i,
    input  logic              tclr_i,
    input  logic [TIW-1:0]    tidx_i,
    input  logic [DUR_W-1:0]  tdur_i,
    output logic [1:0]        state_o,
    output logic              take_o,
    output logic              drop_o,
    output logic [CODE_W:0]   code_o
);

    logic [N_TMR-1:0]            p_set, p_clr, f_set, f_clr, t_set, t_clr;
    logic [N_TMR-1:0]            fire, acc;
    logic [N_TMR-1:0][DUR_W-1:0] dur;
    entry_t                      head;
    logic [CNT_W-1:0]            cnt;
    logic                        pop, head_ok, arm, disarm;
    state_e                      st;

    // port commands beat transition actions; stop beats set
    for (genvar t = 0; t < N_TMR; t++) begin : g_cmd
        assign p_clr[t] = tclr_i && (tidx_i == TIW'(t));
        assign p_set[t] = tset_i && !tclr_i && (tidx_i == TIW'(t));
        if (t == 0) begin : g_arm
            assign f_set[t] = arm;
            assign f_clr[t] = disarm;
        end else begin : g_none
            assign f_set[t] = 1'b0;
            assign f_clr[t] = 1'b0;
        end
        assign t_set[t] = p_set[t] | (f_set[t] & ~(p_set[t] | p_clr[t]));
        assign t_clr[t] = p_clr[t] | (f_clr[t] & ~(p_set[t] | p_clr[t]));
        assign dur[t]   = p_set[t] ? tdur_i : DUR_W'(ARM_DUR);
    end

    assign pop     = step_i && (cnt != '0);
    // a head purged by a port command this cycle is dropped silently
    assign head_ok = pop && !tmr_hit(head, 8'(p_set | p_clr));

    evq_timer_bank #(.N_TMR(N_TMR), .DUR_W(DUR_W)) tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (t_set),
        .clr_i  (t_clr),
        .dur_i  (dur),
        .acc_i  (acc),
        .fire_o (fire)
    );

    evq_queue #(.DEPTH(DEPTH), .N_TMR(N_TMR)) q_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pop_i     (pop),
        .kill_i    (t_set | t_clr),
        .wr_vld_i  (wr_vld_i),
        .wr_code_i (wr_code_i),
        .tmr_req_i (fire),
        .head_o    (head),
        .cnt_o     (cnt),
        .wr_rdy_o  (wr_rdy_o),
        .tmr_acc_o (acc)
    );

    evq_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .head_ok_i (head_ok),
        .head_i    (head),
        .state_o   (st),
        .take_o    (take_o),
        .drop_o    (drop_o),
        .code_o    (code_o),
        .arm_o     (arm),
        .disarm_o  (disarm)
    );

    assign state_o = st;

endmodule

// File: rtl/evq_proc_chk.sv
module evq_proc_chk
    import evq_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic            step_i,
    input logic            tset_i,
    input logic            tclr_i,
    input logic            wr_rdy_o,
    input logic [1:0]      state_o,
    input logic            take_o,
    input logic            drop_o,
    input logic [CODE_W:0] code_o
);

    assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(take_o && drop_o));

    assert_no_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> !(take_o || drop_o));

    assert_drop_keeps_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_o |-> $stable(state_o));

    assert_legal_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != 2'd3);

    assert_run_via_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && state_o == 2'(ST_RUN)) |-> code_o == {1'b0, MSG_ACK});

    assert_expire_from_armed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && code_o == {1'b1, TMR_ARM}) |-> $past(state_o) == 2'(ST_ARMED));

    assert_full_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !wr_rdy_o && !tset_i && !tclr_i) |=> !wr_rdy_o);

endmodule

bind evq_proc evq_proc_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .tset_i   (tset_i),
    .tclr_i   (tclr_i),
    .wr_rdy_o (wr_rdy_o),
    .state_o  (state_o),
    .take_o   (take_o),
    .drop_o   (drop_o),
    .code_o   (code_o)
);

// File: tb/evq_proc_tb_top.sv
module evq_proc_tb_top;
    import evq_pkg::*;

    localparam int DEPTH = 8;
    localparam int ARM   = 6;

    logic       clk = 1'b0, rst_n = 1'b0, step = 1'b1;
    logic       wr_vld = 1'b0;
    logic [2:0] wr_code = '0;
    logic       tset = 1'b0, tclr = 1'b0, tidx = 1'b0;
    logic [7:0] tdur = '0;
    logic       wr_rdy, take, drop;
    logic [1:0] state;
    logic [3:0] code;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    evq_proc #(.DEPTH(DEPTH), .ARM_DUR(ARM)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step),
        .wr_vld_i(wr_vld), .wr_code_i(wr_code), .wr_rdy_o(wr_rdy),
        .tset_i(tset), .tclr_i(tclr), .tidx_i(tidx), .tdur_i(tdur),
        .state_o(state), .take_o(take), .drop_o(drop), .code_o(code)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compares {take, drop, code (only during a strobe), state}
    task automatic obs(string req, bit et, bit ed, logic [3:0] ec, logic [1:0] es);
        logic [3:0] ac, xc;
        ac = (take | drop) ? code : 4'd0;
        xc = (et | ed) ? ec : 4'd0;
        check(req, {8'd0, take, drop, ac, state}, {8'd0, et, ed, xc, es});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(logic [2:0] c);
        wr_vld = 1'b1; wr_code = c;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic tcmd(bit s, bit c, bit idx, logic [7:0] d);
        tset = s; tclr = c; tidx = idx; tdur = d;
        @(negedge clk);
        tset = 1'b0; tclr = 1'b0;
    endtask

    task automatic t_reset();
        obs("R1 reset outputs", 0, 0, 0, 0);
        check("R1 ready after reset", 16'(wr_rdy), 16'd1);
    endtask

    task automatic t_table();
        push(MSG_ACK); tick(); obs("R4 ACK in IDLE dropped", 0, 1, 4'd2, 0);
        push(MSG_START); tick(); obs("R3 ARM", 1, 0, 4'd1, 1);
        tick(); obs("R11 strobe lasts one cycle", 0, 0, 0, 1);
        push(MSG_ACK); tick(); obs("R3 CONFIRM", 1, 0, 4'd2, 2);
        for (int i = 0; i < ARM + 3; i++) begin
            tick(); obs("R9 CONFIRM stops arm timer", 0, 0, 0, 2);
        end
        push(MSG_STOP); tick(); obs("R3 HALT", 1, 0, 4'd3, 0);
    endtask

    task automatic t_order_step();
        step = 1'b0;
        push(MSG_ACK); push(MSG_START); push(MSG_ACK);
        for (int i = 0; i < 3; i++) begin
            tick(); obs("R5 nothing consumed without step", 0, 0, 0, 0);
        end
        step = 1'b1;
        tick(); obs("R2 oldest first", 0, 1, 4'd2, 0);
        tick(); obs("R2 second entry", 1, 0, 4'd1, 1);
        tick(); obs("R2 third entry", 1, 0, 4'd2, 2);
        push(MSG_STOP); tick(); obs("R3 HALT back to idle", 1, 0, 4'd3, 0);
    endtask

    task automatic t_timeout();
        push(MSG_START); tick(); obs("R3 ARM before timeout", 1, 0, 4'd1, 1);
        for (int i = 0; i < ARM; i++) begin
            tick(); obs("R6 no early timeout", 0, 0, 0, 1);
        end
        tick(); obs("R6 EXPIRE via queue", 1, 0, 4'd8, 0);
    endtask

    task automatic t_port_timer();
        tcmd(1, 0, 1, 8'd3);
        for (int i = 0; i < 3; i++) begin
            tick(); obs("R6 timer 1 counting", 0, 0, 0, 0);
        end
        tick(); obs("R4 timer 1 in IDLE dropped", 0, 1, 4'd9, 0);
    endtask

    task automatic t_same_edge();
        step = 1'b0;
        tcmd(1, 0, 1, 8'd2);
        tick();
        push(MSG_STOP);
        step = 1'b1;
        tick(); obs("R7 external first", 0, 1, 4'd3, 0);
        tick(); obs("R7 expiry second", 0, 1, 4'd9, 0);
    endtask

    task automatic t_full();
        step = 1'b0;
        for (int i = 0; i < DEPTH; i++) push(MSG_ACK);
        check("R8 ready low when full", 16'(wr_rdy), 16'd0);
        tcmd(1, 0, 1, 8'd0);
        tick();
        push(MSG_STOP);
        step = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            tick(); obs("R8 drain queued ACK", 0, 1, 4'd2, 0);
        end
        tick(); obs("R8 pending expiry kept", 0, 1, 4'd9, 0);
        tick(); obs("R8 write while full ignored", 0, 0, 0, 0);
        check("R8 ready after drain", 16'(wr_rdy), 16'd1);
    endtask

    task automatic t_purge();
        step = 1'b0;
        tcmd(1, 0, 1, 8'd1);
        tick();
        push(MSG_ACK);
        tcmd(0, 1, 1, 8'd0);
        step = 1'b1;
        tick(); obs("R9 stop purges queued expiry", 0, 1, 4'd2, 0);
        for (int i = 0; i < 3; i++) begin
            tick(); obs("R9 nothing after purge", 0, 0, 0, 0);
        end
    endtask

    task automatic t_restart();
        step = 1'b0;
        tcmd(1, 0, 1, 8'd1);
        tick();
        tcmd(1, 0, 1, 8'd4);
        step = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(); obs("R10 stale expiry purged", 0, 0, 0, 0);
        end
        tick(); obs("R10 restarted duration", 0, 1, 4'd9, 0);
    endtask

    task automatic t_priority();
        push(MSG_START);
        tcmd(0, 1, 0, 8'd0);
        obs("R3 ARM with port stop", 1, 0, 4'd1, 1);
        for (int i = 0; i < ARM + 3; i++) begin
            tick(); obs("R12 port stop beats ARM action", 0, 0, 0, 1);
        end
        push(MSG_STOP); tick(); obs("R3 ABORT", 1, 0, 4'd3, 0);
        push(MSG_START); tick(); obs("R3 ARM again", 1, 0, 4'd1, 1);
        push(MSG_ACK); tick(); obs("R3 CONFIRM again", 1, 0, 4'd2, 2);
        tcmd(1, 0, 1, 8'd2);
        for (int i = 0; i < 2; i++) begin
            tick(); obs("R6 idle timer running", 0, 0, 0, 2);
        end
        tick(); obs("R3 IDLEOUT", 1, 0, 4'd9, 0);
        tcmd(1, 1, 1, 8'd2);
        for (int i = 0; i < 5; i++) begin
            tick(); obs("R12 stop beats set", 0, 0, 0, 0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_table();
        t_order_step();
        t_timeout();
        t_port_timer();
        t_same_edge();
        t_full();
        t_purge();
        t_restart();
        t_priority();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

endmodule